// File: doc/BRIEF.md
# Interrupt Mask and Condition Unit

This block turns the status word of a bus controller into a single level-sensitive interrupt line. It takes the status word and shifts it down by a fixed number of bit positions to form a raw condition vector. It then qualifies that vector with a mask that the host programs, and drives the interrupt while any qualified bit is set. Some register offsets act differently for reads and writes. Software can therefore set or clear chosen mask bits in a single write, with no read-modify-write sequence.

The raw and masked condition vectors and the interrupt line are not tracked continuously. They are captured as snapshots at each register access, read or write, at any offset. Between accesses they hold their values even if the status word moves. A read returns its data one cycle after the read strobe, and that data shows the snapshot taken at the access before. The status bits themselves come from elsewhere.

Top module: `intr_mask_cond`

## Requirements
- R1: After reset the mask, both condition snapshots, the read data output and `irq_o` are all zero.
- R2: A write to offset 0x8 replaces the mask with the write data. A read of offset 0x8 returns the mask as it stood before that access.
- R3: A write to offset 0x9 sets every mask bit that is 1 in the write data and leaves the other mask bits unchanged.
- R4: A write to offset 0xA clears every mask bit that is 0 in the write data and leaves the other mask bits unchanged.
- R5: A read of offset 0x9 returns the raw snapshot, which is the status word shifted right by 16 (condition bit k is status bit k+16; the top 16 bits are zero), as captured at the most recent earlier access. Read data appears on `reg_rdata_o` in the cycle after the read strobe and holds until the next read.
- R6: A read of offset 0xA returns the masked snapshot, which is the raw snapshot ANDed with the mask in force after that earlier access.
- R7: In the cycle after any access, `irq_o` is 1 exactly when the status word at the access, shifted right by 16 and ANDed with the updated mask, is non-zero. `irq_o` is a held level, not a pulse.
- R8: When no access occurs, changes on `status_i` affect neither `irq_o` nor the values later returned from offsets 0x9 and 0xA.
- R9: Status bits 63 down to 55 carry, in that order, invalid command, parity error, back-end overrun, back-end access error, arbitration lost, NACK received, data request, command complete and stop error. They appear as condition bits 47 down to 39.
- R10: An access to any offset other than 0x8, 0x9 or 0xA leaves the mask unchanged. A read there returns zero. Such an access still refreshes the snapshots and `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| status_i | input | 64 | Controller status word |
| reg_addr_i | input | 4 | Register offset of the access |
| reg_wr_i | input | 1 | Write strobe, one cycle per write |
| reg_rd_i | input | 1 | Read strobe, one cycle per read |
| reg_wdata_i | input | 64 | Write data |
| reg_rdata_o | output | 64 | Read data, valid the cycle after the read strobe |
| irq_o | output | 1 | Registered interrupt level |

## Verification
The bench targets the one-access lag on condition reads. A design that returns the live condition instead of the snapshot would return the current status on an offset 0x9 read rather than the value captured at the access before. It also moves the status word while the bus is idle, which catches a design that tracks status continuously: its interrupt would drop before the next access. Set and clear writes use patterns that overlap the existing mask, so a design that swaps OR and AND, or that loads the mask outright, returns the wrong mask on readback. Single-source status words check that each flag lands 16 places lower. Unused offsets are checked to leave the mask alone and read back as zero.

// File: rtl/imc_pkg.sv
package imc_pkg;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_MASK = 2'd1,
        SEL_RAW  = 2'd2,
        SEL_QUAL = 2'd3
    } imc_sel_e;

    localparam int unsigned IMC_ADDR_W   = 4;
    localparam logic [3:0]  IMC_OFS_MASK = 4'h8;
    localparam logic [3:0]  IMC_OFS_RAW  = 4'h9;
    localparam logic [3:0]  IMC_OFS_QUAL = 4'hA;

endpackage

// File: rtl/imc_addr_dec.sv
module imc_addr_dec
    import imc_pkg::*;
#(
    parameter int unsigned     ADDR_W   = 4,
    parameter logic [ADDR_W-1:0] OFS_MASK = ADDR_W'(8),
    parameter logic [ADDR_W-1:0] OFS_RAW  = ADDR_W'(9),
    parameter logic [ADDR_W-1:0] OFS_QUAL = ADDR_W'(10)
) (
    input  logic [ADDR_W-1:0] addr_i,
    output imc_sel_e          sel_o
);
    always_comb begin
        if (addr_i == OFS_MASK) begin
            sel_o = SEL_MASK;
        end else if (addr_i == OFS_RAW) begin
            sel_o = SEL_RAW;
        end else if (addr_i == OFS_QUAL) begin
            sel_o = SEL_QUAL;
        end else begin
            sel_o = SEL_NONE;
        end
    end
endmodule

// File: rtl/imc_mask_next.sv
module imc_mask_next
    import imc_pkg::*;
#(
    parameter int unsigned DATA_W = 64
) (
    input  imc_sel_e          sel_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [DATA_W-1:0] mask_q_i,
    output logic [DATA_W-1:0] mask_d_o
);
    // offset 0x9 writes set bits, offset 0xA writes clear bits
    always_comb begin
        mask_d_o = mask_q_i;
        if (wr_i) begin
            unique case (sel_i)
                SEL_MASK: mask_d_o = wdata_i;
                SEL_RAW:  mask_d_o = mask_q_i | wdata_i;
                SEL_QUAL: mask_d_o = mask_q_i & wdata_i;
                default:  mask_d_o = mask_q_i;
            endcase
        end
    end
endmodule

// File: rtl/imc_cond_eval.sv
module imc_cond_eval #(
    parameter int unsigned DATA_W     = 64,
    parameter int unsigned COND_SHIFT = 16
) (
    input  logic [DATA_W-1:0] status_i,
    input  logic [DATA_W-1:0] mask_i,
    output logic [DATA_W-1:0] raw_o,
    output logic [DATA_W-1:0] qual_o,
    output logic              any_o
);
    for (genvar i = 0; i < int'(DATA_W); i++) begin : g_bit
        if (i + COND_SHIFT < DATA_W) begin : g_src
            assign raw_o[i] = status_i[i+COND_SHIFT];
        end else begin : g_zero
            assign raw_o[i] = 1'b0;
        end
        assign qual_o[i] = raw_o[i] & mask_i[i];
    end

    assign any_o = |qual_o;
endmodule

// File: rtl/imc_rd_mux.sv
module imc_rd_mux
    import imc_pkg::*;
#(
    parameter int unsigned DATA_W = 64
) (
    input  imc_sel_e          sel_i,
    input  logic [DATA_W-1:0] mask_i,
    input  logic [DATA_W-1:0] raw_i,
    input  logic [DATA_W-1:0] qual_i,
    output logic [DATA_W-1:0] rd_o
);
    always_comb begin
        unique case (sel_i)
            SEL_MASK: rd_o = mask_i;
            SEL_RAW:  rd_o = raw_i;
            SEL_QUAL: rd_o = qual_i;
            default:  rd_o = '0;
        endcase
    end
endmodule

// File: rtl/intr_mask_cond.sv
module intr_mask_cond
    import imc_pkg::*;
#(
    parameter int unsigned       DATA_W     = 64,
    parameter int unsigned       COND_SHIFT = 16,
    parameter int unsigned       ADDR_W     = IMC_ADDR_W,
    parameter logic [ADDR_W-1:0] OFS_MASK   = IMC_OFS_MASK,
    parameter logic [ADDR_W-1:0] OFS_RAW    = IMC_OFS_RAW,
    parameter logic [ADDR_W-1:0] OFS_QUAL   = IMC_OFS_QUAL
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] status_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic              reg_wr_i,
    input  logic              reg_rd_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              irq_o
);
    typedef struct packed {
        logic [DATA_W-1:0] mask;
        logic [DATA_W-1:0] raw;
        logic [DATA_W-1:0] qual;
        logic              irq;
        logic [DATA_W-1:0] rdata;
    } imc_state_t;

    imc_state_t state_d, state_q;

    imc_sel_e          sel;
    logic [DATA_W-1:0] mask_d;
    logic [DATA_W-1:0] raw_c;
    logic [DATA_W-1:0] qual_c;
    logic              any_c;
    logic [DATA_W-1:0] rd_val;
    logic              access;

    assign access = reg_wr_i | reg_rd_i;

    imc_addr_dec #(
        .ADDR_W  (ADDR_W),
        .OFS_MASK(OFS_MASK),
        .OFS_RAW (OFS_RAW),
        .OFS_QUAL(OFS_QUAL)
    ) u_dec (
        .addr_i(reg_addr_i),
        .sel_o (sel)
    );

    imc_mask_next #(.DATA_W(DATA_W)) u_mask (
        .sel_i   (sel),
        .wr_i    (reg_wr_i),
        .wdata_i (reg_wdata_i),
        .mask_q_i(state_q.mask),
        .mask_d_o(mask_d)
    );

    // conditions use the mask as it stands after this access
    imc_cond_eval #(.DATA_W(DATA_W), .COND_SHIFT(COND_SHIFT)) u_cond (
        .status_i(status_i),
        .mask_i  (mask_d),
        .raw_o   (raw_c),
        .qual_o  (qual_c),
        .any_o   (any_c)
    );

    imc_rd_mux #(.DATA_W(DATA_W)) u_rd (
        .sel_i (sel),
        .mask_i(state_q.mask),
        .raw_i (state_q.raw),
        .qual_i(state_q.qual),
        .rd_o  (rd_val)
    );

    always_comb begin
        state_d = state_q;
        if (access) begin
            state_d.mask = mask_d;
            state_d.raw  = raw_c;
            state_d.qual = qual_c;
            state_d.irq  = any_c;
        end
        if (reg_rd_i) begin
            state_d.rdata = rd_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign reg_rdata_o = state_q.rdata;
    assign irq_o       = state_q.irq;
endmodule

// File: rtl/imc_checker.sv
module imc_checker #(
    parameter int unsigned       DATA_W     = 64,
    parameter int unsigned       COND_SHIFT = 16,
    parameter int unsigned       ADDR_W     = 4,
    parameter logic [ADDR_W-1:0] OFS_MASK   = ADDR_W'(8),
    parameter logic [ADDR_W-1:0] OFS_RAW    = ADDR_W'(9),
    parameter logic [ADDR_W-1:0] OFS_QUAL   = ADDR_W'(10)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] status_i,
    input logic [ADDR_W-1:0] reg_addr_i,
    input logic              reg_wr_i,
    input logic              reg_rd_i,
    input logic [DATA_W-1:0] reg_wdata_i,
    input logic [DATA_W-1:0] reg_rdata_o,
    input logic              irq_o,
    input logic [DATA_W-1:0] mask_q
);
    logic hit;
    assign hit = (reg_addr_i == OFS_MASK) || (reg_addr_i == OFS_RAW) ||
                 (reg_addr_i == OFS_QUAL);

    assert_mask_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && reg_addr_i == OFS_MASK) |=> (mask_q == $past(reg_wdata_i)));

    assert_mask_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && reg_addr_i == OFS_RAW) |=>
            (mask_q == ($past(mask_q) | $past(reg_wdata_i))));

    assert_mask_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && reg_addr_i == OFS_QUAL) |=>
            (mask_q == ($past(mask_q) & $past(reg_wdata_i))));

    assert_rdata_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd_i |=> $stable(reg_rdata_o));

    assert_irq_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i || reg_rd_i) |=>
            (irq_o == (|(($past(status_i) >> COND_SHIFT) & mask_q))));

    assert_irq_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr_i || reg_rd_i) |=> $stable(irq_o));

    assert_mask_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr_i && hit) |=> $stable(mask_q));
endmodule

bind intr_mask_cond imc_checker #(
    .DATA_W    (DATA_W),
    .COND_SHIFT(COND_SHIFT),
    .ADDR_W    (ADDR_W),
    .OFS_MASK  (OFS_MASK),
    .OFS_RAW   (OFS_RAW),
    .OFS_QUAL  (OFS_QUAL)
) u_imc_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .status_i   (status_i),
    .reg_addr_i (reg_addr_i),
    .reg_wr_i   (reg_wr_i),
    .reg_rd_i   (reg_rd_i),
    .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o),
    .irq_o      (irq_o),
    .mask_q     (state_q.mask)
);

// File: tb/intr_mask_cond_bench.sv
`timescale 1ns/1ps
module intr_mask_cond_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] status_i = '0;
    logic [3:0]  reg_addr_i = '0;
    logic        reg_wr_i = 1'b0;
    logic        reg_rd_i = 1'b0;
    logic [63:0] reg_wdata_i = '0;
    logic [63:0] reg_rdata_o;
    logic        irq_o;

    int unsigned n_vec  = 0;
    int unsigned n_fail = 0;
    int unsigned cycles = 0;

    // reference model state
    logic [63:0] m_mask = '0;
    logic [63:0] m_raw  = '0;
    logic [63:0] m_qual = '0;
    logic        m_irq  = 1'b0;
    logic [63:0] m_rd   = '0;

    always #10 clk = ~clk;

    intr_mask_cond u_intr_mask_cond (
        .clk        (clk),
        .rst_n      (rst_n),
        .status_i   (status_i),
        .reg_addr_i (reg_addr_i),
        .reg_wr_i   (reg_wr_i),
        .reg_rd_i   (reg_rd_i),
        .reg_wdata_i(reg_wdata_i),
        .reg_rdata_o(reg_rdata_o),
        .irq_o      (irq_o)
    );

    function automatic logic [63:0] f_raw(input logic [63:0] s);
        return s >> 16;
    endfunction

    function automatic logic [63:0] f_read(input logic [3:0] a);
        case (a)
            4'h8:    return m_mask;
            4'h9:    return m_raw;
            4'hA:    return m_qual;
            default: return 64'h0;
        endcase
    endfunction

    function automatic logic [63:0] f_mask(input logic [3:0] a, input logic [63:0] d);
        case (a)
            4'h8:    return d;
            4'h9:    return m_mask | d;
            4'hA:    return m_mask & d;
            default: return m_mask;
        endcase
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic access(input logic wr, input logic rd, input logic [3:0] a,
                          input logic [63:0] d);
        @(negedge clk);
        reg_wr_i    = wr;
        reg_rd_i    = rd;
        reg_addr_i  = a;
        reg_wdata_i = d;
        if (rd) m_rd = f_read(a);
        if (wr) m_mask = f_mask(a, d);
        m_raw  = f_raw(status_i);
        m_qual = m_raw & m_mask;
        m_irq  = |m_qual;
        @(negedge clk);
        reg_wr_i = 1'b0;
        reg_rd_i = 1'b0;
        chk("R7 irq after access", {63'h0, irq_o}, {63'h0, m_irq});
        if (rd) begin
            case (a)
                4'h8:    chk("R2 mask read", reg_rdata_o, m_rd);
                4'h9:    chk("R5 raw read", reg_rdata_o, m_rd);
                4'hA:    chk("R6 masked read", reg_rdata_o, m_rd);
                default: chk("R10 unused read", reg_rdata_o, m_rd);
            endcase
        end else begin
            chk("R5 rdata held", reg_rdata_o, m_rd);
        end
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected<=100000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        logic [63:0] hold_raw;
        void'($urandom(32'd4711));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 rdata reset", reg_rdata_o, 64'h0);
        chk("R1 irq reset", {63'h0, irq_o}, 64'h0);
        access(1'b0, 1'b1, 4'h8, '0);   // R1 mask reads zero
        access(1'b0, 1'b1, 4'hA, '0);   // R1 masked snapshot zero

        // R2 direct load
        access(1'b1, 1'b0, 4'h8, 64'hDEAD_BEEF_0123_4567);
        access(1'b0, 1'b1, 4'h8, '0);
        access(1'b1, 1'b0, 4'h8, 64'h0000_0000_0000_00F0);
        // R3 set bits
        access(1'b1, 1'b0, 4'h9, 64'h0000_0000_0000_0F30);
        access(1'b0, 1'b1, 4'h8, '0);
        // R4 clear bits
        access(1'b1, 1'b0, 4'hA, 64'hFFFF_FFFF_FFFF_F0A0);
        access(1'b0, 1'b1, 4'h8, '0);

        // R9 flag positions: invalid command and stop error
        access(1'b1, 1'b0, 4'h8, '1);
        status_i = 64'h8000_0000_0000_0000;
        access(1'b0, 1'b1, 4'h9, '0);
        access(1'b0, 1'b1, 4'h9, '0);
        chk("R9 invalid command at bit 47", reg_rdata_o, 64'h0000_8000_0000_0000);
        status_i = 64'h0080_0000_0000_0000;
        access(1'b0, 1'b1, 4'h9, '0);
        access(1'b0, 1'b1, 4'h9, '0);
        chk("R9 stop error at bit 39", reg_rdata_o, 64'h0000_0080_0000_0000);
        hold_raw = reg_rdata_o;

        // R8 idle status change
        status_i = 64'h0;
        repeat (6) @(negedge clk);
        chk("R8 irq idle", {63'h0, irq_o}, 64'h1);
        access(1'b0, 1'b1, 4'h9, '0);
        chk("R8 snapshot kept", reg_rdata_o, hold_raw);

        // R10 unused offsets
        access(1'b1, 1'b0, 4'h8, 64'h1234_5678_9ABC_DEF0);
        access(1'b1, 1'b0, 4'h3, 64'h0);
        access(1'b1, 1'b0, 4'hB, 64'hFFFF_FFFF_FFFF_FFFF);
        access(1'b0, 1'b1, 4'h8, '0);
        access(1'b0, 1'b1, 4'h3, '0);

        // masked-off source keeps irq low (R6)
        access(1'b1, 1'b0, 4'h8, 64'h0000_0000_FFFF_0000);
        status_i = 64'hFFFF_0000_0000_0000;
        access(1'b0, 1'b1, 4'hA, '0);
        access(1'b0, 1'b1, 4'hA, '0);

        for (int i = 0; i < 400; i++) begin
            logic [3:0]  a;
            logic [63:0] d;
            int unsigned op;
            op = $urandom_range(0, 3);
            case ($urandom_range(0, 4))
                0: a = 4'h8;
                1: a = 4'h9;
                2: a = 4'hA;
                3: a = 4'h9;
                default: a = 4'($urandom_range(0, 15));
            endcase
            d = {$urandom(), $urandom()};
            if ($urandom_range(0, 1) == 1) status_i = {$urandom(), $urandom()} &
                                                     {$urandom(), $urandom()};
            if (op == 0) begin
                repeat ($urandom_range(1, 3)) @(negedge clk);
                chk("R8 irq idle random", {63'h0, irq_o}, {63'h0, m_irq});
            end else if (op == 1) begin
                access(1'b1, 1'b0, a, d);
            end else begin
                access(1'b0, 1'b1, a, '0);
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule